// File: doc/BRIEF.md
# Strobe-Driven Slave FIFO Endpoint Port

This block is the peripheral end of a byte-wide asynchronous FIFO link. An external master, running without a shared clock, moves bytes with three active-low strobes (write, read, packet end) and a 2-bit FIFO select. Behind the port sit two byte FIFOs. The receive FIFO collects bytes that the master writes and hands them to local logic as a packet stream. The transmit FIFO accepts bytes from a local stream, and the master reads them out. The strobes pass through two-flop synchronisers into the local clock, and each strobe acts once per edge it produces.

Written bytes stay hidden from the local receive stream until their packet is committed. A packet commits on its own when its byte count reaches the selected packet length (long or short). The master can also commit a shorter packet early with the packet-end strobe. A packet-end strobe that arrives with no bytes pending can, when enabled, emit a zero-length packet marker. Two active-low flags report the state of the FIFOs: one is low while the transmit FIFO is empty, the other is low while the receive FIFO is full. Writing to a full FIFO or reading from an empty one has no effect on the FIFO and sets a sticky error output. The read data bus is driven only while the read strobe is low.

Top module: `sfp_endpoint`

## Requirements
- R1: After reset, flag_empty_n is 0, flag_full_n is 1, out_tvalid is 0, in_tready is 1, and err_wr and err_rd are both 0.
- R2: Write and packet-end strobes act only when fifo_sel is RX_ADDR (default 2). A read strobe acts only when the fifo_sel value held at its falling edge is TX_ADDR (default 0). Strobes at any other address change nothing. port_dout shows the transmit FIFO head while fifo_sel equals TX_ADDR and shows 0 otherwise.
- R3: Written bytes do not appear on the receive stream until their packet is committed. With len_sel=1, a packet commits automatically on its LEN_LONG-th byte, and out_tlast is 1 on that byte only.
- R4: With len_sel=0, a packet commits automatically on its LEN_SHORT-th byte, and out_tlast marks that byte.
- R5: A packet-end strobe with 1 to len-1 bytes pending commits those bytes as one packet, and out_tlast marks the final byte.
- R6: A packet-end strobe with no bytes pending adds one entry with out_tzero=1 and out_tlast=1 when zlp_en=1, and adds nothing when zlp_en=0.
- R7: A write strobe held low for many clocks stores exactly one byte.
- R8: flag_full_n is 0 while the receive FIFO holds DEPTH entries. A write in that state is discarded and sets err_wr, which stays set until reset.
- R9: bus_drive is 1 exactly while slrd_n is 0. port_dout holds the head byte for the whole low phase of the read strobe, and the FIFO advances to the next byte after the strobe is released. flag_empty_n is 0 once the transmit FIFO is drained.
- R10: A read strobe on an empty transmit FIFO leaves the FIFO unchanged and sets err_rd, which stays set until reset.
- R11: in_tready is 0 while the transmit FIFO holds DEPTH bytes. While in_tready is 0, in_tvalid is ignored and no byte is stored.
- R12: While out_tvalid=1 and out_tready=0, out_tdata, out_tlast and out_tvalid hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slrd_n | input | 1 | Read strobe from the master, active low; also enables the data bus |
| slwr_n | input | 1 | Write strobe from the master, active low |
| pktend_n | input | 1 | Packet-end strobe from the master, active low |
| fifo_sel | input | 2 | Selects one of four FIFO addresses |
| port_din | input | DATA_W | Write data from the master |
| port_dout | output | DATA_W | Read data to the master |
| bus_drive | output | 1 | Pad enable for port_dout |
| flag_empty_n | output | 1 | Low while the transmit FIFO is empty |
| flag_full_n | output | 1 | Low while the receive FIFO is full |
| len_sel | input | 1 | 1 selects LEN_LONG, 0 selects LEN_SHORT as the commit length |
| zlp_en | input | 1 | Enables zero-length packet markers |
| out_tdata | output | DATA_W | Receive stream data |
| out_tvalid | output | 1 | Receive stream valid |
| out_tready | input | 1 | Receive stream ready |
| out_tlast | output | 1 | Last byte of a packet |
| out_tzero | output | 1 | Entry is a zero-length packet marker |
| in_tdata | input | DATA_W | Transmit stream data |
| in_tvalid | input | 1 | Transmit stream valid |
| in_tready | output | 1 | Transmit stream ready |
| err_wr | output | 1 | Sticky: a write hit a full FIFO |
| err_rd | output | 1 | Sticky: a read hit an empty FIFO |

## Verification
The bench builds the block with DEPTH=16, LEN_LONG=8 and LEN_SHORT=4. With these values it can sweep every packet size from one byte up to both commit lengths, each size committed either by the length limit or by a packet-end strobe. The small depth also lets the bench fill both FIFOs completely, so it can drive the full and empty corners, including the discarded write, the discarded push and the read from an empty FIFO.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // Strobe channel indices into the synchroniser vector.
  localparam int STB_RD  = 0;
  localparam int STB_WR  = 1;
  localparam int STB_PE  = 2;
  localparam int NUM_STB = 3;

  typedef logic [1:0] fifo_addr_t;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_n,
  output logic [N-1:0] sync_n
);
  // Two-flop synchroniser per channel; idle level of every strobe is high.
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic m_q, s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= 1'b1;
        s_q <= 1'b1;
      end else begin
        m_q <= async_n[g];
        s_q <= m_q;
      end
    end
    assign sync_n[g] = s_q;
  end
endmodule

// File: rtl/sfp_rx_fifo.sv
module sfp_rx_fifo #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int LEN_LONG  = 512,
  parameter int LEN_SHORT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              pe_ev,
  input  logic [DATA_W-1:0] din,
  input  logic              len_sel,
  input  logic              zlp_en,
  output logic              full,
  output logic              err,
  output logic [DATA_W-1:0] out_tdata,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic              out_tlast,
  output logic              out_tzero
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(LEN_LONG + 1);

  logic [DATA_W-1:0] mem_data [DEPTH];
  logic              mem_last [DEPTH];
  logic              mem_zero [DEPTH];

  logic [PW-1:0] wr_q, wr_d, cm_q, cm_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, len_now;
  logic          err_q, err_d;

  logic              we, mark_last;
  logic [AW-1:0]     w_idx;
  logic [DATA_W-1:0] w_data;
  logic              w_last, w_zero;

  assign len_now = len_sel ? CW'(LEN_LONG) : CW'(LEN_SHORT);
  assign full    = (wr_q - rd_q) == PW'(DEPTH);

  always_comb begin
    wr_d      = wr_q;
    cm_d      = cm_q;
    rd_d      = rd_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    we        = 1'b0;
    mark_last = 1'b0;
    w_idx     = wr_q[AW-1:0];
    w_data    = din;
    w_last    = 1'b0;
    w_zero    = 1'b0;
    if (wr_ev) begin
      if (full) begin
        err_d = 1'b1;
      end else begin
        we     = 1'b1;
        w_last = (cnt_q + CW'(1)) >= len_now;
        wr_d   = wr_q + PW'(1);
        if (w_last) begin
          cm_d  = wr_q + PW'(1);
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end else if (pe_ev) begin
      if (cnt_q != '0) begin
        // Mark the newest still-hidden byte as packet end and publish.
        mark_last = 1'b1;
        w_idx     = wr_q[AW-1:0] - AW'(1);
        cm_d      = wr_q;
        cnt_d     = '0;
      end else if (zlp_en && !full) begin
        we     = 1'b1;
        w_data = '0;
        w_last = 1'b1;
        w_zero = 1'b1;
        wr_d   = wr_q + PW'(1);
        cm_d   = wr_q + PW'(1);
      end
    end
    if (out_tvalid && out_tready) rd_d = rd_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      cm_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      cm_q  <= cm_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem_data[w_idx] <= w_data;
      mem_last[w_idx] <= w_last;
      mem_zero[w_idx] <= w_zero;
    end else if (mark_last) begin
      mem_last[w_idx] <= 1'b1;
    end
  end

  assign out_tvalid = rd_q != cm_q;
  assign out_tdata  = mem_data[rd_q[AW-1:0]];
  assign out_tlast  = mem_last[rd_q[AW-1:0]];
  assign out_tzero  = mem_zero[rd_q[AW-1:0]];
  assign err        = err_q;
endmodule

// File: rtl/sfp_tx_fifo.sv
module sfp_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_tdata,
  input  logic              in_tvalid,
  output logic              in_tready,
  input  logic              rd_ev,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic              err_q, err_d, push;

  assign empty     = wr_q == rd_q;
  assign in_tready = (wr_q - rd_q) != PW'(DEPTH);
  assign push      = in_tvalid && in_tready;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    err_d = err_q;
    if (push) wr_d = wr_q + PW'(1);
    if (rd_ev) begin
      if (empty) err_d = 1'b1;
      else       rd_d  = rd_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= in_tdata;
  end

  assign head = mem[rd_q[AW-1:0]];
  assign err  = err_q;
endmodule

// File: rtl/sfp_endpoint.sv
module sfp_endpoint #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int LEN_LONG  = 512,
  parameter int LEN_SHORT = 64,
  parameter int RX_ADDR   = 2,
  parameter int TX_ADDR   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slrd_n,
  input  logic              slwr_n,
  input  logic              pktend_n,
  input  logic [1:0]        fifo_sel,
  input  logic [DATA_W-1:0] port_din,
  output logic [DATA_W-1:0] port_dout,
  output logic              bus_drive,
  output logic              flag_empty_n,
  output logic              flag_full_n,
  input  logic              len_sel,
  input  logic              zlp_en,
  output logic [DATA_W-1:0] out_tdata,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic              out_tlast,
  output logic              out_tzero,
  input  logic [DATA_W-1:0] in_tdata,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic              err_wr,
  output logic              err_rd
);
  import sfp_pkg::*;

  localparam fifo_addr_t RX_A = fifo_addr_t'(RX_ADDR);
  localparam fifo_addr_t TX_A = fifo_addr_t'(TX_ADDR);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sh_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i_n = rst_sh_q[1];

  // Strobe synchronisation and edge detection.
  logic [NUM_STB-1:0] stb_raw_n, stb_sync_n, stb_prev_q, stb_fall;
  logic               rd_rise;
  assign stb_raw_n[STB_RD] = slrd_n;
  assign stb_raw_n[STB_WR] = slwr_n;
  assign stb_raw_n[STB_PE] = pktend_n;

  sfp_sync #(.N(NUM_STB)) u_sync (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .async_n(stb_raw_n),
    .sync_n (stb_sync_n)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) stb_prev_q <= '1;
    else          stb_prev_q <= stb_sync_n;
  end
  assign stb_fall = stb_prev_q & ~stb_sync_n;
  assign rd_rise  = ~stb_prev_q[STB_RD] & stb_sync_n[STB_RD];

  // Address of a read is captured at its falling edge, used at release.
  fifo_addr_t rd_sel_q, rd_sel_d;
  always_comb begin
    rd_sel_d = rd_sel_q;
    if (stb_fall[STB_RD]) rd_sel_d = fifo_sel;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rd_sel_q <= '0;
    else          rd_sel_q <= rd_sel_d;
  end

  logic wr_ev, pe_ev, rd_ev, rx_full, tx_empty;
  logic [DATA_W-1:0] tx_head;
  assign wr_ev = stb_fall[STB_WR] && (fifo_sel == RX_A);
  assign pe_ev = stb_fall[STB_PE] && (fifo_sel == RX_A);
  assign rd_ev = rd_rise && (rd_sel_q == TX_A);

  sfp_rx_fifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_ev     (wr_ev),
    .pe_ev     (pe_ev),
    .din       (port_din),
    .len_sel   (len_sel),
    .zlp_en    (zlp_en),
    .full      (rx_full),
    .err       (err_wr),
    .out_tdata (out_tdata),
    .out_tvalid(out_tvalid),
    .out_tready(out_tready),
    .out_tlast (out_tlast),
    .out_tzero (out_tzero)
  );

  sfp_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .in_tdata (in_tdata),
    .in_tvalid(in_tvalid),
    .in_tready(in_tready),
    .rd_ev    (rd_ev),
    .head     (tx_head),
    .empty    (tx_empty),
    .err      (err_rd)
  );

  assign port_dout    = (fifo_sel == TX_A) ? tx_head : '0;
  assign bus_drive    = ~slrd_n;
  assign flag_empty_n = ~tx_empty;
  assign flag_full_n  = ~rx_full;
endmodule

// File: rtl/sfp_endpoint_chk.sv
module sfp_endpoint_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_empty_n,
  input logic              flag_full_n,
  input logic [DATA_W-1:0] out_tdata,
  input logic              out_tvalid,
  input logic              out_tready,
  input logic              out_tlast,
  input logic              out_tzero,
  input logic              in_tvalid,
  input logic              in_tready,
  input logic              err_wr,
  input logic              err_rd
);
  p_err_wr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr |=> err_wr);
  p_err_wr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_wr) |-> $past(!flag_full_n));
  p_full_persist_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_full_n && !(out_tvalid && out_tready)) |=> !flag_full_n);
  p_err_rd_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_rd |=> err_rd);
  p_err_rd_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_rd) |-> $past(!flag_empty_n));
  p_empty_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_empty_n && !(in_tvalid && in_tready)) |=> !flag_empty_n);
  p_ready_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tready |-> flag_empty_n);
  p_zero_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && out_tzero) |-> out_tlast);
  p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata) && $stable(out_tlast)));
endmodule

bind sfp_endpoint sfp_endpoint_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag_empty_n(flag_empty_n),
  .flag_full_n (flag_full_n),
  .out_tdata   (out_tdata),
  .out_tvalid  (out_tvalid),
  .out_tready  (out_tready),
  .out_tlast   (out_tlast),
  .out_tzero   (out_tzero),
  .in_tvalid   (in_tvalid),
  .in_tready   (in_tready),
  .err_wr      (err_wr),
  .err_rd      (err_rd)
);

// File: tb/sim_sfp_endpoint.sv
module sim_sfp_endpoint;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int LLONG = 8;
  localparam int LSHORT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slrd_n = 1'b1, slwr_n = 1'b1, pktend_n = 1'b1;
  logic [1:0] fifo_sel = 2'd2;
  logic [DW-1:0] port_din = '0, in_tdata = '0;
  logic len_sel = 1'b1, zlp_en = 1'b0, out_tready = 1'b0, in_tvalid = 1'b0;
  logic [DW-1:0] port_dout, out_tdata;
  logic bus_drive, flag_empty_n, flag_full_n, out_tvalid, out_tlast, out_tzero;
  logic in_tready, err_wr, err_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sfp_endpoint #(.DATA_W(DW), .DEPTH(DEPTH), .LEN_LONG(LLONG), .LEN_SHORT(LSHORT),
                 .RX_ADDR(2), .TX_ADDR(0)) u0 (
    .clk(clk), .rst_n(rst_n), .slrd_n(slrd_n), .slwr_n(slwr_n), .pktend_n(pktend_n),
    .fifo_sel(fifo_sel), .port_din(port_din), .port_dout(port_dout),
    .bus_drive(bus_drive), .flag_empty_n(flag_empty_n), .flag_full_n(flag_full_n),
    .len_sel(len_sel), .zlp_en(zlp_en), .out_tdata(out_tdata), .out_tvalid(out_tvalid),
    .out_tready(out_tready), .out_tlast(out_tlast), .out_tzero(out_tzero),
    .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .err_wr(err_wr), .err_rd(err_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [DW-1:0] d, input int low);
    @(negedge clk);
    fifo_sel = sel; port_din = d; slwr_n = 1'b0;
    wait_n(low);
    slwr_n = 1'b1;
    wait_n(6);
  endtask

  task automatic do_pktend(input logic [1:0] sel);
    @(negedge clk);
    fifo_sel = sel; pktend_n = 1'b0;
    wait_n(6);
    pktend_n = 1'b1;
    wait_n(6);
  endtask

  // Drain n bytes with values base+i; last flag only on the final byte.
  task automatic drain(input int n, input int base, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      out_tready = 1'b0;
      check(req, {31'd0, out_tvalid}, 32'd1);
      check(req, {24'd0, out_tdata}, 32'(base + i) & 32'hFF);
      check(req, {31'd0, out_tlast}, {31'd0, i == n - 1});
      check(req, {31'd0, out_tzero}, 32'd0);
      if (i == 0) begin
        @(negedge clk);
        check("R12", {24'd0, out_tdata}, 32'(base) & 32'hFF);
      end
      out_tready = 1'b1;
    end
    @(negedge clk);
    out_tready = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk);
    in_tdata = d; in_tvalid = 1'b1;
    @(negedge clk);
    in_tvalid = 1'b0;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    // R1 reset state
    check("R1", {31'd0, flag_empty_n}, 32'd0);
    check("R1", {31'd0, flag_full_n}, 32'd1);
    check("R1", {31'd0, out_tvalid}, 32'd0);
    check("R1", {31'd0, in_tready}, 32'd1);
    check("R1", {31'd0, err_wr}, 32'd0);
    check("R1", {31'd0, err_rd}, 32'd0);

    // R3/R4/R5 sweep of every packet size for both commit lengths
    for (int ls = 1; ls >= 0; ls--) begin
      int len;
      len_sel = ls[0];
      len = ls ? LLONG : LSHORT;
      for (int n = 1; n <= len; n++) begin
        for (int i = 0; i < n; i++) do_write(2'd2, DW'(n * 16 + i), 6);
        if (n < len) begin
          check("R3", {31'd0, out_tvalid}, 32'd0);
          do_pktend(2'd2);
          drain(n, n * 16, "R5");
        end else begin
          drain(n, n * 16, ls ? "R3" : "R4");
        end
        check(ls ? "R3" : "R4", {31'd0, out_tvalid}, 32'd0);
      end
    end
    len_sel = 1'b1;

    // R6 zero-length packets
    zlp_en = 1'b1;
    do_pktend(2'd2);
    check("R6", {31'd0, out_tvalid}, 32'd1);
    check("R6", {31'd0, out_tzero}, 32'd1);
    check("R6", {31'd0, out_tlast}, 32'd1);
    @(negedge clk); out_tready = 1'b1;
    @(negedge clk); out_tready = 1'b0;
    check("R6", {31'd0, out_tvalid}, 32'd0);
    zlp_en = 1'b0;
    do_pktend(2'd2);
    check("R6", {31'd0, out_tvalid}, 32'd0);

    // R7 long write strobe moves one byte
    do_write(2'd2, 8'hA5, 14);
    do_pktend(2'd2);
    drain(1, 8'hA5, "R7");
    check("R7", {31'd0, out_tvalid}, 32'd0);

    // R2 unmapped addresses ignored for write and packet end
    do_write(2'd0, 8'h11, 6);
    do_write(2'd1, 8'h22, 6);
    do_write(2'd3, 8'h33, 6);
    zlp_en = 1'b1;
    do_pktend(2'd1);
    check("R2", {31'd0, out_tvalid}, 32'd0);
    zlp_en = 1'b0;
    do_write(2'd2, 8'h5C, 6);
    do_pktend(2'd2);
    drain(1, 8'h5C, "R2");
    check("R2", {31'd0, out_tvalid}, 32'd0);

    // R8 full receive FIFO
    for (int i = 0; i < DEPTH; i++) do_write(2'd2, DW'(8'h80 + i), 6);
    check("R8", {31'd0, flag_full_n}, 32'd0);
    check("R8", {31'd0, err_wr}, 32'd0);
    do_write(2'd2, 8'hEE, 6);
    check("R8", {31'd0, err_wr}, 32'd1);
    drain(LLONG, 8'h80, "R8");
    drain(LLONG, 8'h80 + LLONG, "R8");
    check("R8", {31'd0, out_tvalid}, 32'd0);
    check("R8", {31'd0, flag_full_n}, 32'd1);
    check("R8", {31'd0, err_wr}, 32'd1);

    // R11 full transmit FIFO
    for (int i = 0; i < DEPTH; i++) push(DW'(8'h40 + i));
    check("R11", {31'd0, in_tready}, 32'd0);
    push(8'hEE);

    // R2 read at receive address leaves transmit FIFO alone
    @(negedge clk);
    fifo_sel = 2'd2; slrd_n = 1'b0;
    wait_n(3);
    check("R2", {24'd0, port_dout}, 32'd0);
    slrd_n = 1'b1;
    wait_n(6);
    fifo_sel = 2'd0;
    @(negedge clk);
    check("R2", {24'd0, port_dout}, 32'h40);

    // R9 read out every byte
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      fifo_sel = 2'd0; slrd_n = 1'b0;
      @(negedge clk);
      check("R9", {31'd0, bus_drive}, 32'd1);
      check("R9", {24'd0, port_dout}, 32'(8'h40 + i));
      wait_n(4);
      check("R9", {24'd0, port_dout}, 32'(8'h40 + i));
      slrd_n = 1'b1;
      @(negedge clk);
      check("R9", {31'd0, bus_drive}, 32'd0);
      wait_n(5);
    end
    check("R9", {31'd0, flag_empty_n}, 32'd0);
    check("R11", {31'd0, in_tready}, 32'd1);
    check("R10", {31'd0, err_rd}, 32'd0);

    // R10 read from empty
    @(negedge clk);
    slrd_n = 1'b0;
    wait_n(6);
    slrd_n = 1'b1;
    wait_n(6);
    check("R10", {31'd0, err_rd}, 32'd1);
    check("R10", {31'd0, flag_empty_n}, 32'd0);
    push(8'h77);
    @(negedge clk);
    check("R10", {24'd0, port_dout}, 32'h77);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule